// File: doc/BRIEF.md
# Uniformly Sampled Pulse-Width Modulator

This block produces a single gate waveform from a binary counter, which acts as the carrier, and a comparator that checks the counter against a held duty value. The duty command is copied into the held register once per modulation period, at a sampling instant that depends on the carrier shape. The gate waveform for a period is fixed from that instant on, so a new command acts one period later. Three carrier shapes are provided. The sawtooth carrier gives a trailing-edge pulse or a leading-edge pulse. The up/down triangular carrier samples the duty either at the centre of the on-time (counter at zero) or at the centre of the off-time (counter at its peak).

Two single-cycle pulses go to the controlling processor. One marks the start of each modulation period and is used for synchronisation. The other marks each cycle where the counter meets the comparison value. The period value sets the carrier length, so it also sets the usable duty resolution. A short period leaves fewer usable duty steps than the counter width provides. The period is taken only at the carrier's zero point, so a change of period never cuts a running cycle short.

Top module: `sampled_pwm`

## Requirements
- R1: While reset is asserted with enable low, the gate and both pulse outputs are low. Reset leaves the counter at 0, the held duty at 0, the held period at 2 and the held mode at trailing-edge.
- R2: Mode 0 is trailing-edge. With held period P, the counter runs 0,1,...,P-1 and then wraps to 0. The gate is high exactly while the counter is below the held duty D.
- R3: In every mode, a held duty of 0 keeps the gate low for the whole period. A held duty greater than or equal to P keeps the gate high for the whole period. Neither case produces any stray gate pulse.
- R4: Mode 1 is leading-edge. The counter runs as in R2, and the gate is high while the counter is at least P-D. The pulse therefore fills the last D cycles of the period.
- R5: Modes 2 and 3 are triangular. The counter runs 0,1,...,P,P-1,...,1, which is 2P cycles, and the gate is high while the counter is below D.
- R6: The match pulse is high for exactly the cycles where the counter equals the comparison value. That value is D in modes 0, 2 and 3. In mode 1 it is P-D, or 0 when D is at least P.
- R7: The period-start pulse is high in the cycle where the counter is 0 in modes 0, 1 and 2. In mode 3 it is high in the cycle where the counter is at its peak P.
- R8: Mode and period are taken from the inputs on the clock edge that enters counter value 0. A period input below 2 is taken as 2. The duty is taken on that same edge if the incoming mode is not 3. In mode 3 the duty is taken on the edge that enters the peak instead. A duty change at any other time has no effect until the next sampling instant.
- R9: While enable is low, the counter is held at 0, the gate is low and neither pulse fires. On every disabled edge, period, mode and duty are taken from the inputs. The first enabled cycle is counter value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the carrier when high |
| periodIn | input | CNT_W | Carrier period command P |
| dutyIn | input | CNT_W | Duty command D |
| modeIn | input | 2 | Carrier mode: 0 trailing, 1 leading, 2 triangle sampled at zero, 3 triangle sampled at peak |
| gateOut | output | 1 | PWM gate signal |
| irqStart | output | 1 | Period-start pulse |
| irqMatch | output | 1 | Counter match pulse |

## Verification
A counter that runs one step too far or turns back at the wrong value shows up within one period. The symptom is a gate edge or a match pulse on the wrong cycle, or a period-start pulse that repeats at the wrong spacing. A held duty or period that loads at the wrong instant cannot be seen until a command changes mid-period. For that reason the stimulus changes commands at random points and compares every cycle against a position-based model. With that stimulus, such a fault changes the gate width within one period of the change. A wrong mode decode at a triangle peak moves the period-start pulse by P cycles in the next period.

// File: rtl/sampled_pwm_pkg.sv
package sampled_pwm_pkg;

  typedef enum logic [1:0] {
    MODE_TRAIL   = 2'd0,
    MODE_LEAD    = 2'd1,
    MODE_TRI_BOT = 2'd2,
    MODE_TRI_TOP = 2'd3
  } carrierMode_t;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } countDir_t;

  // Strobes sent from the sequencer to the datapath
  typedef struct packed {
    logic clearCnt;
    logic incCnt;
    logic decCnt;
    logic loadFrame;
    logic loadDuty;
  } pwmStrobes_t;

  localparam int MIN_PERIOD = 2;

endpackage

// File: rtl/sampled_pwm_ctrl.sv
module sampled_pwm_ctrl
  import sampled_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [1:0]         modeIn,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [CNT_W-1:0]   heldPeriod,
  input  carrierMode_t       heldMode,
  output pwmStrobes_t        stb
);

  countDir_t dir, nextDir;
  logic [CNT_W-1:0] lastUp;
  logic isTri;
  logic incomingTop;

  assign lastUp      = heldPeriod - CNT_W'(1);
  assign isTri       = (heldMode == MODE_TRI_BOT) || (heldMode == MODE_TRI_TOP);
  assign incomingTop = (carrierMode_t'(modeIn) == MODE_TRI_TOP);

  always_comb begin
    stb     = '0;
    nextDir = dir;
    if (!enable) begin
      stb.clearCnt  = 1'b1;
      stb.loadFrame = 1'b1;
      stb.loadDuty  = 1'b1;
      nextDir       = DIR_UP;
    end else if (!isTri) begin
      if (cnt == lastUp) begin
        stb.clearCnt  = 1'b1;
        stb.loadFrame = 1'b1;
        stb.loadDuty  = !incomingTop;
      end else begin
        stb.incCnt = 1'b1;
      end
    end else if (dir == DIR_UP) begin
      stb.incCnt = 1'b1;
      if (cnt == lastUp) begin
        nextDir      = DIR_DOWN;
        stb.loadDuty = (heldMode == MODE_TRI_TOP);
      end
    end else begin
      if (cnt == CNT_W'(1)) begin
        stb.clearCnt  = 1'b1;
        stb.loadFrame = 1'b1;
        stb.loadDuty  = !incomingTop;
        nextDir       = DIR_UP;
      end else begin
        stb.decCnt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir <= DIR_UP;
    else        dir <= nextDir;
  end

endmodule

// File: rtl/sampled_pwm_dp.sv
module sampled_pwm_dp
  import sampled_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pwmStrobes_t        stb,
  input  logic [CNT_W-1:0]   periodIn,
  input  logic [CNT_W-1:0]   dutyIn,
  input  logic [1:0]         modeIn,
  output logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]   heldPeriod,
  output logic [CNT_W-1:0]   heldDuty,
  output carrierMode_t       heldMode,
  output logic               gateRaw,
  output logic               startRaw,
  output logic               matchRaw
);

  localparam logic [CNT_W-1:0] PERIOD_FLOOR = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0] periodClamped;
  logic [CNT_W-1:0] leadCmp;
  logic [CNT_W-1:0] cmpVal;
  logic             dutyFull;

  assign periodClamped = (periodIn < PERIOD_FLOOR) ? PERIOD_FLOOR : periodIn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (stb.clearCnt) begin
      cnt <= '0;
    end else if (stb.incCnt) begin
      cnt <= cnt + CNT_W'(1);
    end else if (stb.decCnt) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heldPeriod <= PERIOD_FLOOR;
      heldMode   <= MODE_TRAIL;
    end else if (stb.loadFrame) begin
      heldPeriod <= periodClamped;
      heldMode   <= carrierMode_t'(modeIn);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            heldDuty <= '0;
    else if (stb.loadDuty) heldDuty <= dutyIn;
  end

  assign dutyFull = (heldDuty >= heldPeriod);
  assign leadCmp  = dutyFull ? '0 : (heldPeriod - heldDuty);

  always_comb begin
    case (heldMode)
      MODE_LEAD: begin
        cmpVal  = leadCmp;
        gateRaw = (heldDuty != '0) && (cnt >= leadCmp);
      end
      MODE_TRI_BOT, MODE_TRI_TOP: begin
        cmpVal  = heldDuty;
        gateRaw = dutyFull || (cnt < heldDuty);
      end
      default: begin
        cmpVal  = heldDuty;
        gateRaw = (cnt < heldDuty);
      end
    endcase
  end

  assign matchRaw = (cnt == cmpVal);
  assign startRaw = (heldMode == MODE_TRI_TOP) ? (cnt == heldPeriod) : (cnt == '0);

endmodule

// File: rtl/sampled_pwm.sv
module sampled_pwm
  import sampled_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] dutyIn,
  input  logic [1:0]       modeIn,
  output logic             gateOut,
  output logic             irqStart,
  output logic             irqMatch
);

  pwmStrobes_t      stb;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] heldPeriod;
  logic [CNT_W-1:0] heldDuty;
  carrierMode_t     heldMode;
  logic             gateRaw, startRaw, matchRaw;

  sampled_pwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .modeIn(modeIn),
    .cnt(cnt), .heldPeriod(heldPeriod), .heldMode(heldMode), .stb(stb)
  );

  sampled_pwm_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .periodIn(periodIn), .dutyIn(dutyIn), .modeIn(modeIn),
    .cnt(cnt), .heldPeriod(heldPeriod), .heldDuty(heldDuty), .heldMode(heldMode),
    .gateRaw(gateRaw), .startRaw(startRaw), .matchRaw(matchRaw)
  );

  assign gateOut  = enable && rst_n && gateRaw;
  assign irqStart = enable && rst_n && startRaw;
  assign irqMatch = enable && rst_n && matchRaw;

endmodule

// File: rtl/sampled_pwm_chk.sv
module sampled_pwm_chk
  import sampled_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             gateOut,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] heldPeriod,
  input logic [CNT_W-1:0] heldDuty,
  input carrierMode_t     heldMode
);

  // R9
  idle_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0));

  // R9
  first_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> (cnt == '0));

  // R2
  saw_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (heldMode == MODE_TRAIL || heldMode == MODE_LEAD)) |-> (cnt < heldPeriod));

  // R5
  tri_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (heldMode == MODE_TRI_BOT || heldMode == MODE_TRI_TOP)) |-> (cnt <= heldPeriod));

  // R8
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(heldPeriod));

  // R3
  full_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && heldDuty >= heldPeriod) |-> gateOut);

  // R3
  full_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (heldDuty == '0) |-> !gateOut);

endmodule

bind sampled_pwm sampled_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .gateOut(gateOut),
  .cnt(cnt), .heldPeriod(heldPeriod), .heldDuty(heldDuty), .heldMode(heldMode)
);

// File: tb/sampled_pwm_test.sv
module sampled_pwm_test;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [W-1:0] periodIn = 16'd10;
  logic [W-1:0] dutyIn = 16'd0;
  logic [1:0] modeIn = 2'd0;
  logic gateOut, irqStart, irqMatch;

  int vectors = 0;
  int errors = 0;
  bit finished = 0;

  // bench model: position within the period plus held values
  int mPos, mP, mD, mMode;

  always #4 clk = ~clk;

  sampled_pwm #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .periodIn(periodIn), .dutyIn(dutyIn), .modeIn(modeIn),
    .gateOut(gateOut), .irqStart(irqStart), .irqMatch(irqMatch)
  );

  function automatic int clampP(input int p);
    return (p < 2) ? 2 : p;
  endfunction

  function automatic int carrier();
    if (mMode < 2) return mPos;
    return (mPos <= mP) ? mPos : 2 * mP - mPos;
  endfunction

  function automatic bit expGate();
    int c = carrier();
    if (!enable || !rst_n) return 0;
    case (mMode)
      0: return c < mD;
      1: return (mD != 0) && (c >= mP - mD);
      default: return (c < mD) || (mD >= mP);
    endcase
  endfunction

  function automatic bit expMatch();
    int c = carrier();
    if (!enable || !rst_n) return 0;
    if (mMode == 1) return c == ((mD >= mP) ? 0 : mP - mD);
    return c == mD;
  endfunction

  function automatic bit expStart();
    if (!enable || !rst_n) return 0;
    if (mMode == 3) return mPos == mP;
    return mPos == 0;
  endfunction

  function automatic string gateTag();
    if (!rst_n) return "R1";
    if (!enable) return "R9";
    if (mD == 0 || mD >= mP) return "R3";
    if (mMode == 0) return "R2";
    if (mMode == 1) return "R4";
    return "R5";
  endfunction

  task automatic modelReset();
    mPos = 0; mP = 2; mD = 0; mMode = 0;
  endtask

  task automatic modelAdvance();
    int len;
    if (!rst_n) begin
      modelReset();
      return;
    end
    if (!enable) begin
      mPos = 0; mP = clampP(int'(periodIn)); mMode = int'(modeIn); mD = int'(dutyIn);
      return;
    end
    len = (mMode < 2) ? mP : 2 * mP;
    mPos = mPos + 1;
    if (mPos == len) begin
      mPos = 0; mP = clampP(int'(periodIn)); mMode = int'(modeIn);
      if (modeIn != 2'd3) mD = int'(dutyIn);
    end else if (mMode == 3 && mPos == mP) begin
      mD = int'(dutyIn);
    end
  endtask

  task automatic compareOutputs();
    bit eg = expGate();
    bit es = expStart();
    bit em = expMatch();
    vectors++;
    if (gateOut !== eg) begin
      errors++;
      $display("FAIL %s gate t=%0t got %b expected %b (mode %0d P %0d D %0d pos %0d)",
               gateTag(), $time, gateOut, eg, mMode, mP, mD, mPos);
    end
    if (irqStart !== es) begin
      errors++;
      $display("FAIL %s irqStart t=%0t got %b expected %b", (!rst_n || !enable) ? "R9" : "R7",
               $time, irqStart, es);
    end
    if (irqMatch !== em) begin
      errors++;
      $display("FAIL %s irqMatch t=%0t got %b expected %b", (!rst_n || !enable) ? "R9" : "R6",
               $time, irqMatch, em);
    end
  endtask

  task automatic cycle(input bit en, input int p, input int d, input int m);
    @(negedge clk);
    enable = en; periodIn = W'(p); dutyIn = W'(d); modeIn = 2'(m);
    #1;
    compareOutputs();
    @(posedge clk);
    modelAdvance();
  endtask

  task automatic run(input bit en, input int p, input int d, input int m, input int n);
    for (int i = 0; i < n; i++) cycle(en, p, d, m);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    int seedDummy;
    int p, d, m;
    bit en;
    seedDummy = int'($urandom(32'd7715));
    modelReset();
    // R1: outputs quiet while reset is held
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      enable = 1'b0;
      #1;
      compareOutputs();
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    modelAdvance();

    $display("R2 trailing-edge periods");
    run(1, 10, 3, 0, 35);
    $display("R3 duty extremes");
    run(1, 10, 0, 0, 25);
    run(1, 10, 10, 0, 25);
    run(1, 10, 15, 1, 25);
    run(1, 10, 0, 2, 45);
    run(1, 6, 6, 3, 30);
    $display("R4 leading-edge periods");
    run(1, 9, 4, 1, 30);
    $display("R5 R7 triangular carrier, both sampling points");
    run(1, 7, 3, 2, 40);
    run(1, 7, 5, 3, 40);
    $display("R8 duty change mid-period is deferred");
    run(1, 12, 4, 0, 18);
    run(1, 12, 9, 0, 3);
    run(1, 12, 2, 0, 30);
    run(1, 5, 2, 3, 7);
    run(1, 5, 4, 3, 20);
    $display("R8 period below two is taken as two");
    run(1, 0, 1, 0, 10);
    run(1, 1, 1, 2, 12);
    $display("R9 enable dropped and restored");
    run(1, 8, 3, 0, 5);
    run(0, 8, 5, 1, 6);
    run(1, 8, 5, 1, 20);

    // constrained random commands with occasional mode and enable changes
    p = 10; d = 4; m = 0; en = 1;
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 15) == 0) p = int'($urandom_range(0, 24));
      if ($urandom_range(0, 5) == 0) d = int'($urandom_range(0, 27));
      if ($urandom_range(0, 60) == 0) m = int'($urandom_range(0, 3));
      if (en) en = ($urandom_range(0, 200) != 0);
      else    en = ($urandom_range(0, 3) == 0);
      cycle(en, p, d, m);
    end
    finishRun();
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired got running expected finished");
    finishRun();
  end

endmodule